// File: doc/BRIEF.md
# PWM Fault Protection and Interrupt Controller

This block sits beside a multi-generator PWM engine and handles everything that happens when something goes wrong or when a generator reloads. Four active-high fault inputs are synchronized into the bus clock domain. While a fault input is high, it latches a status flag and immediately forces the matching output channel inactive. Three reload strobes, one per generator, latch their own status flags. Each of the seven flags can raise the single CPU interrupt line when its individual enable bit is set. Software clears a flag by writing a one to its bit.

Releasing a channel after its fault has gone away depends on the generator state. While the generator runs, a released channel waits for the next half-period boundary strobe, so the output restarts on a clean PWM edge. While the generator is stopped, the channel is released on the very next bus clock. That also holds when software drives the pins directly. Software pin control never bypasses the fault force.

Top module: `pwmfp_irq`

## Requirements
- R1: After reset, all flags and enables read as zero, every `ch_dis` bit is low and `irq` is low.
- R2: A fault input held high sets its flag, read at address 0 bits 3..0 (bit i for fault i), on the third rising edge after the input rises (two synchronizer stages plus the flag register).
- R3: Writing address 0 with a one in a bit clears that flag. A set event in the same cycle keeps the flag set, including a fault input that is still high.
- R4: A one-cycle pulse on `reload_stb[g]` sets the reload flag at address 0 bit 4+g on the next rising edge.
- R5: `irq` is high exactly when some flag and its enable bit are both set. The enables sit at address 1 and use the same bit layout as the flags.
- R6: A fault input held high sets `ch_dis` for its channel on the third rising edge after the input rises.
- R7: While `gen_en` is high, a disabled channel stays disabled until a rising edge that sees `half_stb` high while its synchronized fault is low. A `half_stb` seen while the fault is still present does not release the channel.
- R8: While `gen_en` is low, a disabled channel is released on the third rising edge after its fault input falls.
- R9: `pin_out[i]` is 0 whenever `ch_dis[i]` is high, whatever `sw_ctl` is. Otherwise it equals `sw_val[i]` when `sw_ctl[i]` is high and `pwm_val[i]` when it is low.
- R10: The enable register at address 1 reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 7 | Write data |
| reg_rdata | output | 7 | Read data for the selected register |
| fault_in | input | 4 | Asynchronous active-high fault inputs |
| reload_stb | input | 3 | Reload-cycle start strobes for generators A, B, C |
| gen_en | input | 1 | PWM generator running |
| half_stb | input | 1 | Half-period boundary strobe |
| sw_ctl | input | 4 | Per-channel software pin control select |
| sw_val | input | 4 | Software pin values |
| pwm_val | input | 4 | Generator pin values |
| ch_dis | output | 4 | Per-channel fault disable |
| pin_out | output | 4 | Channel outputs after the fault force |
| irq | output | 1 | CPU interrupt request |

## Verification
The bound checker watches the cycle-level rules on every edge: a synchronized fault sets both its flag and its disable, a running generator holds a disabled channel until a boundary strobe, a stopped generator releases at once, a disabled channel drives its pin low, and a write-one clears a flag when no set event coincides. The bench scenarios show the absolute latencies from the raw fault pins through the synchronizer. They also cover set-over-clear priority while a fault persists and while a reload strobe coincides with the clear, the muxing between software and generator pin values, and the enable read-back and interrupt gating as seen through the register port.

// File: rtl/pwmfp_pkg.sv
package pwmfp_pkg;
  localparam int unsigned N_FAULT = 4;
  localparam int unsigned N_GEN   = 3;
  localparam int unsigned N_SRC   = N_FAULT + N_GEN;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic ADDR_FLAGS = 1'b0;
  localparam logic ADDR_ENAB  = 1'b1;
endpackage

// File: rtl/pwmfp_rstsync.sv
module pwmfp_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwmfp_sync.sv
module pwmfp_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0] stage_q [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] stage_d;
    always_comb begin
      stage_d = {stage_q[i][STAGES-2:0], async_in[i]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_d;
    end
    assign sync_out[i] = stage_q[i][STAGES-1];
  end
endmodule

// File: rtl/pwmfp_flags.sv
module pwmfp_flags #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_ev,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] flags_d;
  logic [WIDTH-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    flags_d = (flags & ~clr_eff) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end
endmodule

// File: rtl/pwmfp_release.sv
module pwmfp_release #(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] fault_s,
  input  logic            gen_en,
  input  logic            half_stb,
  output logic [N_CH-1:0] dis
);
  logic            rel_ok;
  logic [N_CH-1:0] dis_d;

  always_comb begin
    rel_ok = gen_en ? half_stb : 1'b1;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_comb begin
      if (fault_s[i])      dis_d[i] = 1'b1;
      else if (rel_ok)     dis_d[i] = 1'b0;
      else                 dis_d[i] = dis[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis <= '0;
    else        dis <= dis_d;
  end
endmodule

// File: rtl/pwmfp_irq.sv
module pwmfp_irq
  import pwmfp_pkg::*;
#(
  parameter int unsigned NF = N_FAULT,
  parameter int unsigned NG = N_GEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [NF+NG-1:0] reg_wdata,
  output logic [NF+NG-1:0] reg_rdata,
  input  logic [NF-1:0]    fault_in,
  input  logic [NG-1:0]    reload_stb,
  input  logic             gen_en,
  input  logic             half_stb,
  input  logic [NF-1:0]    sw_ctl,
  input  logic [NF-1:0]    sw_val,
  input  logic [NF-1:0]    pwm_val,
  output logic [NF-1:0]    ch_dis,
  output logic [NF-1:0]    pin_out,
  output logic             irq
);
  localparam int unsigned NS = NF + NG;

  logic          rst_sync_n;
  logic [NF-1:0] fault_s;
  logic [NS-1:0] set_ev;
  logic [NS-1:0] flags;
  logic [NS-1:0] enables;
  logic [NS-1:0] enables_d;
  logic          en_we;
  logic          flag_we;

  pwmfp_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pwmfp_sync #(.WIDTH(NF), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_in(fault_in), .sync_out(fault_s)
  );

  assign set_ev  = {reload_stb, fault_s};
  assign flag_we = reg_wr && (reg_addr == ADDR_FLAGS);
  assign en_we   = reg_wr && (reg_addr == ADDR_ENAB);

  pwmfp_flags #(.WIDTH(NS)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_ev(set_ev),
    .clr_we(flag_we), .clr_mask(reg_wdata), .flags(flags)
  );

  pwmfp_release #(.N_CH(NF)) u_rel (
    .clk(clk), .rst_n(rst_sync_n), .fault_s(fault_s),
    .gen_en(gen_en), .half_stb(half_stb), .dis(ch_dis)
  );

  always_comb begin
    enables_d = en_we ? reg_wdata : enables;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) enables <= '0;
    else             enables <= enables_d;
  end

  always_comb begin
    reg_rdata = (reg_addr == ADDR_ENAB) ? enables : flags;
    irq       = |(flags & enables);
  end

  for (genvar i = 0; i < NF; i++) begin : g_pin
    always_comb begin
      if (ch_dis[i])     pin_out[i] = 1'b0;
      else if (sw_ctl[i]) pin_out[i] = sw_val[i];
      else               pin_out[i] = pwm_val[i];
    end
  end
endmodule

// File: rtl/pwmfp_irq_chk.sv
module pwmfp_irq_chk #(
  parameter int unsigned NF = 4,
  parameter int unsigned NG = 3
) (
  input logic             clk,
  input logic             rst_ok,
  input logic [NF-1:0]    fault_s,
  input logic [NF-1:0]    ch_dis,
  input logic [NF-1:0]    pin_out,
  input logic             gen_en,
  input logic             half_stb,
  input logic [NG-1:0]    reload_stb,
  input logic [NF+NG-1:0] flags,
  input logic [NF+NG-1:0] enables,
  input logic [NF+NG-1:0] set_ev,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [NF+NG-1:0] reg_wdata,
  input logic             irq
);
  for (genvar i = 0; i < NF; i++) begin : g_ch
    a_r2_fault_sets_flag: assert property (@(posedge clk) disable iff (!rst_ok)
      fault_s[i] |=> flags[i]);
    a_r6_fault_sets_dis: assert property (@(posedge clk) disable iff (!rst_ok)
      fault_s[i] |=> ch_dis[i]);
    a_r7_hold_running: assert property (@(posedge clk) disable iff (!rst_ok)
      (ch_dis[i] && gen_en && !half_stb) |=> ch_dis[i]);
    a_r8_release_stopped: assert property (@(posedge clk) disable iff (!rst_ok)
      (!fault_s[i] && !gen_en) |=> !ch_dis[i]);
    a_r9_pin_forced: assert property (@(posedge clk) disable iff (!rst_ok)
      ch_dis[i] |-> !pin_out[i]);
  end

  for (genvar g = 0; g < NG; g++) begin : g_gen
    a_r4_reload_sets_flag: assert property (@(posedge clk) disable iff (!rst_ok)
      reload_stb[g] |=> flags[NF+g]);
  end

  for (genvar k = 0; k < NF + NG; k++) begin : g_src
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_ok)
      (reg_wr && !reg_addr && reg_wdata[k] && !set_ev[k]) |=> !flags[k]);
  end

  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    ((flags & enables) == '0) |-> !irq);
endmodule

bind pwmfp_irq pwmfp_irq_chk #(.NF(NF), .NG(NG)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .fault_s(fault_s), .ch_dis(ch_dis),
  .pin_out(pin_out), .gen_en(gen_en), .half_stb(half_stb),
  .reload_stb(reload_stb), .flags(flags), .enables(enables),
  .set_ev(set_ev), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq)
);

// File: tb/pwmfp_irq_bench.sv
module pwmfp_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_DIS = 1, K_IRQ = 2, K_PIN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [6:0] reg_wdata = '0;
  logic [6:0] reg_rdata;
  logic [3:0] fault_in = '0;
  logic [2:0] reload_stb = '0;
  logic       gen_en = 1'b0;
  logic       half_stb = 1'b0;
  logic [3:0] sw_ctl = '0, sw_val = '0, pwm_val = '0;
  logic [3:0] ch_dis, pin_out;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int    kind;
    int    exp;
    string req;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmfp_irq u_pwmfp_irq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_in(fault_in),
    .reload_stb(reload_stb), .gen_en(gen_en), .half_stb(half_stb),
    .sw_ctl(sw_ctl), .sw_val(sw_val), .pwm_val(pwm_val),
    .ch_dis(ch_dis), .pin_out(pin_out), .irq(irq)
  );

  // monitor: compares the head item against the live outputs, then retires it
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        item_t it;
        int act;
        it = sb_q[0];
        case (it.kind)
          K_RD:    act = int'(reg_rdata);
          K_DIS:   act = int'(ch_dis);
          K_IRQ:   act = int'(irq);
          default: act = int'(pin_out);
        endcase
        total++;
        if (act != it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic expect_val(int kind, int exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic expect_rd(logic a, int exp, string req);
    reg_addr = a;
    #1;
    expect_val(K_RD, exp, req);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic a, logic [6:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    expect_rd(1'b0, 0, "R1 flags");
    expect_rd(1'b1, 0, "R1 enables");
    expect_val(K_DIS, 0, "R1 ch_dis");
    expect_val(K_IRQ, 0, "R1 irq");
    step(1);

    // R6 / R2 fault 0 latency, generator stopped
    fault_in[0] = 1'b1;
    step(2);
    expect_val(K_DIS, 0, "R6 before third edge");
    step(1);
    expect_val(K_DIS, 1, "R6 third edge");
    expect_rd(1'b0, 7'h01, "R2 fault flag");
    expect_val(K_IRQ, 0, "R5 masked");
    step(1);
    reg_write(1'b1, 7'h01);
    expect_val(K_IRQ, 1, "R5 enabled");
    expect_rd(1'b1, 7'h01, "R10 enable readback");
    step(1);

    // R3 clear while fault still high is overridden
    reg_write(1'b0, 7'h01);
    expect_rd(1'b0, 7'h01, "R3 set beats clear");
    step(1);

    // R8 release on stopped generator
    fault_in[0] = 1'b0;
    step(2);
    expect_val(K_DIS, 1, "R8 still disabled");
    step(1);
    expect_val(K_DIS, 0, "R8 released");
    reg_write(1'b0, 7'h01);
    expect_rd(1'b0, 7'h00, "R3 cleared");
    expect_val(K_IRQ, 0, "R5 cleared irq");
    step(1);

    // R7 running generator holds until boundary
    gen_en = 1'b1;
    fault_in[1] = 1'b1;
    step(4);
    expect_val(K_DIS, 4'b0010, "R6 ch1 disabled");
    half_stb = 1'b1;
    step(1);
    half_stb = 1'b0;
    expect_val(K_DIS, 4'b0010, "R7 boundary during fault");
    // R9 fault force beats software control
    sw_ctl = 4'b0110; sw_val = 4'b0110; pwm_val = 4'b0000;
    #1;
    expect_val(K_PIN, 4'b0100, "R9 forced and sw");
    step(1);
    fault_in[1] = 1'b0;
    step(6);
    expect_val(K_DIS, 4'b0010, "R7 waits for boundary");
    half_stb = 1'b1;
    step(1);
    half_stb = 1'b0;
    expect_val(K_DIS, 4'b0000, "R7 released at boundary");
    expect_val(K_PIN, 4'b0110, "R9 sw values after release");
    sw_ctl = 4'b0000; pwm_val = 4'b1001;
    #1;
    expect_val(K_PIN, 4'b1001, "R9 generator values");
    step(1);
    gen_en = 1'b0;

    // R4 reload flags
    reg_write(1'b0, 7'h7F);
    reload_stb[1] = 1'b1;
    step(1);
    reload_stb[1] = 1'b0;
    expect_rd(1'b0, 7'h20, "R4 reload B");
    expect_val(K_IRQ, 0, "R5 reload masked");
    step(1);
    reg_write(1'b1, 7'h20);
    expect_val(K_IRQ, 1, "R5 reload irq");
    step(1);
    reload_stb[1] = 1'b1;
    reg_write(1'b0, 7'h20);
    reload_stb[1] = 1'b0;
    expect_rd(1'b0, 7'h20, "R3 strobe beats clear");
    step(1);
    reg_write(1'b0, 7'h20);
    expect_rd(1'b0, 7'h00, "R3 reload cleared");
    expect_val(K_IRQ, 0, "R5 irq dropped");
    step(1);
    reload_stb = 3'b101;
    step(1);
    reload_stb = '0;
    expect_rd(1'b0, 7'h50, "R4 reload A and C");
    step(1);
    reg_write(1'b1, 7'h5A);
    expect_rd(1'b1, 7'h5A, "R10 enable pattern");
    expect_val(K_IRQ, 1, "R5 reload C enabled");
    step(1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule